// File: doc/BRIEF.md
# Hot-Plug Slot Command Completion Controller

This block holds the control and status registers of one hot-plug capable downstream port slot and tracks the hot-plug commands that software issues to it. Software reaches three registers over a 16-bit write/read bus: a read-only capability word pair, a control register and an event status register. Every write to the control register starts a hot-plug command. The command finishes a fixed number of cycles later and sets the command-completed status flag. This happens whatever the slot implements in the way of indicators, power switching or interlocks.

Four sensor strobes (attention button, power fault, retention-latch sensor change and presence change) set their own status flags. A single interrupt line pulses when an event flag goes from clear to set while that event is enabled and the master hot-plug interrupt enable is on. Status flags are cleared by writing 1 to them. A flag that is still set blocks any further interrupt for that event until software clears it.

Top module: `slot_cmd_ctrl`

## Requirements
- R1: After reset, control reads 0x0000, status reads 0x0000, no command is in flight and irq_o is 0.
- R2: Offset 0 reads 0x0001: bit 0 means the slot is hot-plug capable, and bit 1, the "no command completion support" flag, reads 0. Offset 1 reads the SLOT_NUM parameter. Writes to offsets 0 and 1 change nothing.
- R3: Control at offset 2 keeps wdata bits 5:0 and reads them back, with bits 15:6 reading 0. The layout is: bit 0 button enable, bit 1 power-fault enable, bit 2 sensor-change enable, bit 3 presence enable, bit 4 completion enable, bit 5 master hot-plug interrupt enable.
- R4: Every write to offset 2 starts a command, whatever value is written (0 included). Status bit 4 (command completed) becomes readable as 1 exactly CMD_LAT cycles after the clock edge that takes the write, and not earlier.
- R5: A control write that lands while a command is in flight restarts the latency count. Only one completion is reported, CMD_LAT cycles after the last write.
- R6: Status at offset 3 holds event flags in bits 4:0: button 0, power fault 1, sensor change 2, presence 3, completion 4. Writing 1 to a bit clears it and writing 0 leaves it alone, so 0x1f clears all five. If a set and a clear of the same bit fall in the same cycle, the set wins. Bits 15:5 read 0.
- R7: A high cycle on btn_press_i, pwr_fault_i, mrl_chg_i or pres_chg_i sets status bit 0, 1, 2 or 3 respectively.
- R8: irq_o is high for one cycle, in the same cycle that a status flag first reads 1, when that flag went from 0 to 1 while its enable bit and control bit 5 were both 1.
- R9: A completion or event that sets a flag while its enable or control bit 5 is 0 still sets the flag but raises no interrupt. Enabling notifications afterwards raises none either.
- R10: An event that occurs while its flag is already 1 gives no interrupt. After software clears the flag, the next such event interrupts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register word offset |
| wr_en_i | input | 1 | Write strobe, one write per high cycle |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| btn_press_i | input | 1 | Attention button event strobe |
| pwr_fault_i | input | 1 | Power fault event strobe |
| mrl_chg_i | input | 1 | Retention-latch sensor change strobe |
| pres_chg_i | input | 1 | Presence change strobe |
| irq_o | output | 1 | Interrupt pulse |

## Verification
Sensor strobes and status clears take effect at the next clock edge, so their effect on rdata_o and irq_o shows in the cycle right after the stimulus. A completion shows exactly CMD_LAT edges after the control write, and irq_o rises in the same cycle as the flag it reports. The bench drives inputs just after a rising edge and keeps a behavioural model that advances on the same edge. It compares irq_o and rdata_o against that model at every falling edge. Directed checks of the latency sample one cycle before and at the due cycle, which exposes a completion that comes early or late.

// File: rtl/slot_cmd_pkg.sv
package slot_cmd_pkg;
  localparam int DATA_W = 16;
  localparam int EVT_N  = 5;
  localparam int CTRL_W = 6;
  localparam int EVT_CC = 4;
  localparam int CTL_HPIE = 5;

  typedef enum logic [1:0] {
    REG_CAP_LO = 2'd0,
    REG_CAP_HI = 2'd1,
    REG_CTRL   = 2'd2,
    REG_STAT   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/slot_cmd_timer.sv
module slot_cmd_timer #(
  parameter int CMD_LAT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic done_o,
  output logic busy_o
);
  localparam int CW = $clog2(CMD_LAT + 1);
  localparam logic [CW-1:0] LAT_V = CW'(CMD_LAT);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= LAT_V;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) busy_q <= 1'b0;
    end
  end

  // a restart in the final cycle suppresses the old completion
  assign done_o = busy_q && (cnt_q == CW'(1)) && !start_i;
  assign busy_o = busy_q;

  a_r5_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q != '0 && cnt_q <= LAT_V));
  a_r5_single_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r4_start_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (busy_q && cnt_q == LAT_V));
endmodule

// File: rtl/slot_evt_status.sv
module slot_evt_status
  import slot_cmd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EVT_N-2:0] sens_i,
  input  logic             cmd_done_i,
  input  logic             clr_we_i,
  input  logic [EVT_N-1:0] clr_mask_i,
  input  logic [EVT_N-1:0] en_i,
  input  logic             hpie_i,
  output logic [EVT_N-1:0] stat_o,
  output logic             irq_o
);
  logic [EVT_N-1:0] set_v, stat_q, fresh_v;
  logic             irq_q;

  assign set_v = {cmd_done_i, sens_i};

  for (genvar i = 0; i < EVT_N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stat_q[i] <= 1'b0;
      else         stat_q[i] <= set_v[i] | (stat_q[i] & ~(clr_we_i & clr_mask_i[i]));
    end

    a_r6_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_we_i && clr_mask_i[i] && !set_v[i]) |=> !stat_q[i]);
    a_r7_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_v[i] |=> stat_q[i]);
  end

  // only a clear-to-set transition can interrupt
  assign fresh_v = set_v & ~stat_q & en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= hpie_i & (|fresh_v);
  end

  assign stat_o = stat_q;
  assign irq_o  = irq_q;

  a_r10_full_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&stat_q) |=> !irq_o);
  a_r9_hpie_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hpie_i |=> !irq_o);
  a_r4_cc_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_done_i |=> stat_q[EVT_CC]);
endmodule

// File: rtl/slot_cmd_ctrl.sv
module slot_cmd_ctrl
  import slot_cmd_pkg::*;
#(
  parameter int CMD_LAT  = 16,
  parameter int SLOT_NUM = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              btn_press_i,
  input  logic              pwr_fault_i,
  input  logic              mrl_chg_i,
  input  logic              pres_chg_i,
  output logic              irq_o
);
  localparam logic [DATA_W-1:0] CAP_LO = DATA_W'(1); // capable=1, no-completion=0
  localparam logic [DATA_W-1:0] CAP_HI = DATA_W'(SLOT_NUM);

  logic [CTRL_W-1:0] ctrl_q;
  logic [EVT_N-1:0]  stat;
  logic              ctrl_we, stat_we, cmd_done, cmd_busy;
  logic              unused_bits;

  assign ctrl_we = wr_en_i && (addr_i == REG_CTRL);
  assign stat_we = wr_en_i && (addr_i == REG_STAT);
  assign unused_bits = ^wdata_i[DATA_W-1:CTRL_W] ^ cmd_busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= wdata_i[CTRL_W-1:0];
  end

  slot_cmd_timer #(.CMD_LAT(CMD_LAT)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(ctrl_we),
    .done_o (cmd_done),
    .busy_o (cmd_busy)
  );

  slot_evt_status u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sens_i    ({pres_chg_i, mrl_chg_i, pwr_fault_i, btn_press_i}),
    .cmd_done_i(cmd_done),
    .clr_we_i  (stat_we),
    .clr_mask_i(wdata_i[EVT_N-1:0]),
    .en_i      (ctrl_q[EVT_N-1:0]),
    .hpie_i    (ctrl_q[CTL_HPIE]),
    .stat_o    (stat),
    .irq_o     (irq_o)
  );

  always_comb begin
    unique case (reg_addr_e'(addr_i))
      REG_CAP_LO: rdata_o = CAP_LO;
      REG_CAP_HI: rdata_o = CAP_HI;
      REG_CTRL:   rdata_o = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
      default:    rdata_o = {{(DATA_W-EVT_N){1'b0}}, stat};
    endcase
  end

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat == '0) |-> !irq_o);
  a_r3_ctrl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_we |=> $stable(ctrl_q));
endmodule

// File: tb/slot_cmd_ctrl_test.sv
`timescale 1ns/1ps
module slot_cmd_ctrl_test;
  localparam int LAT  = 16;
  localparam int SLOT = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] addr = 2'd3;
  logic we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic btn = 0, pf = 0, mrl = 0, pres = 0;
  logic irq;

  int tests = 0, fails = 0, cyc = 0, irq_cnt = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  slot_cmd_ctrl #(.CMD_LAT(LAT), .SLOT_NUM(SLOT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .btn_press_i(btn), .pwr_fault_i(pf), .mrl_chg_i(mrl),
    .pres_chg_i(pres), .irq_o(irq));

  // behavioural reference
  int m_cnt = 0;
  bit m_busy = 0, m_irq = 0;
  bit [4:0] m_stat = '0;
  bit [5:0] m_ctrl = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_busy = 0; m_irq = 0; m_stat = '0; m_ctrl = '0;
    end else begin
      bit wc, ws, fin;
      bit [4:0] ev, nw;
      wc  = we && addr == 2'd2;
      ws  = we && addr == 2'd3;
      fin = m_busy && m_cnt == 1 && !wc;
      ev  = {fin, pres, mrl, pf, btn};
      nw  = ev & ~m_stat & m_ctrl[4:0];
      m_irq = m_ctrl[5] && (nw != 0);
      m_stat = (m_stat & ~(ws ? wdata[4:0] : 5'd0)) | ev;
      if (wc) begin m_ctrl = wdata[5:0]; m_busy = 1; m_cnt = LAT; end
      else if (m_busy) begin m_cnt--; if (m_cnt == 0) m_busy = 0; end
    end
  end

  function automatic logic [15:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return 16'h0001;
      2'd1: return 16'(SLOT);
      2'd2: return {10'd0, m_ctrl};
      default: return {11'd0, m_stat};
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (irq) irq_cnt++;
      chk(irq == m_irq, "R8 irq_o vs model", irq, m_irq);
      chk(rdata == m_read(addr), "R6 rdata_o vs model", rdata, m_read(addr));
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    addr = a; wdata = d; we = 1; tick(); we = 0; wdata = '0; addr = 2'd3;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [15:0] exp, input string tag);
    addr = a; @(negedge clk); chk(rdata == exp, tag, rdata, exp); tick(); addr = 2'd3;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(irq == 0, "R1 irq after reset", irq, 0);
    chk(rdata == 0, "R1 status after reset", rdata, 0);
    tick();
    rd_chk(2'd2, 16'h0000, "R1 control after reset");

    // R2 capability
    rd_chk(2'd0, 16'h0001, "R2 cap low");
    rd_chk(2'd1, 16'(SLOT), "R2 cap high slot number");
    wr(2'd0, 16'hffff); wr(2'd1, 16'h0000);
    rd_chk(2'd0, 16'h0001, "R2 cap low after write");
    rd_chk(2'd1, 16'(SLOT), "R2 cap high after write");

    // R3 control write masks upper bits (starts a command too)
    wr(2'd2, 16'hffc0);
    rd_chk(2'd2, 16'h0000, "R3 upper bits dropped");
    repeat (LAT + 2) tick();
    wr(2'd3, 16'h001f);

    // R4 and R9: write 0, completion at LAT, no interrupt
    irq_cnt = 0;
    wr(2'd2, 16'h0000);
    repeat (LAT - 1) tick();
    @(negedge clk); chk(rdata[4] == 0, "R4 cc not early", rdata[4], 0);
    tick();
    @(negedge clk); chk(rdata[4] == 1, "R4 cc at latency", rdata[4], 1);
    tick();
    chk(irq_cnt == 0, "R9 no irq while disabled", irq_cnt, 0);

    // R9/R10: enabling with cc still set -> completion gives no irq
    wr(2'd2, 16'h0030);
    repeat (LAT + 2) tick();
    chk(irq_cnt == 0, "R10 no irq with flag pending", irq_cnt, 0);

    // R6: write 0 leaves, write-1 clears
    wr(2'd3, 16'h0000);
    @(negedge clk); chk(rdata[4] == 1, "R6 write 0 keeps flag", rdata[4], 1);
    tick();
    wr(2'd3, 16'h0010);
    @(negedge clk); chk(rdata == 0, "R6 w1c clears", rdata, 0);
    tick();

    // R8: completion with enables on and flag clear -> one pulse at latency
    irq_cnt = 0;
    wr(2'd2, 16'h0030);
    repeat (LAT - 1) tick();
    @(negedge clk); chk(irq == 0, "R8 irq not early", irq, 0);
    tick();
    @(negedge clk); chk(irq == 1, "R8 irq with cc", irq, 1);
    tick();
    @(negedge clk); chk(irq == 0, "R8 irq one cycle", irq, 0);
    tick();
    chk(irq_cnt == 1, "R8 irq count", irq_cnt, 1);

    // R5: restart while busy -> one completion LAT after last write
    wr(2'd3, 16'h001f);
    irq_cnt = 0;
    wr(2'd2, 16'h0030);
    repeat (5) tick();
    wr(2'd2, 16'h0030);
    repeat (LAT - 1) tick();
    @(negedge clk); chk(rdata[4] == 0, "R5 restart delays cc", rdata[4], 0);
    tick();
    @(negedge clk); chk(rdata[4] == 1, "R5 cc after last write", rdata[4], 1);
    repeat (LAT + 2) tick();
    chk(irq_cnt == 1, "R5 single completion", irq_cnt, 1);

    // R7 sensors with R8 per-event enables
    wr(2'd3, 16'h001f);
    wr(2'd2, 16'h0021);
    repeat (LAT + 2) tick();
    irq_cnt = 0;
    btn = 1; tick(); btn = 0;
    @(negedge clk); chk(rdata[0] == 1 && irq == 1, "R7 button sets bit0 and irq", {irq, rdata[0]}, 3);
    tick();
    pf = 1; mrl = 1; tick(); pf = 0; mrl = 0;
    @(negedge clk); chk(rdata[4:0] == 5'h17, "R7 pf and mrl bits", rdata[4:0], 5'h17);
    chk(irq == 0, "R9 disabled events no irq", irq, 0);
    tick();
    btn = 1; tick(); btn = 0;
    @(negedge clk); chk(irq == 0, "R10 button repeat no irq", irq, 0);
    tick();
    wr(2'd3, 16'h0001);
    btn = 1; tick(); btn = 0;
    @(negedge clk); chk(irq == 1, "R10 irq after clear", irq, 1);
    tick();

    // R6 set wins over same-cycle clear
    pres = 1; addr = 2'd3; wdata = 16'h0008; we = 1; tick();
    pres = 0; we = 0; wdata = '0;
    @(negedge clk); chk(rdata[3] == 1, "R6 set beats clear", rdata[3], 1);
    tick();
    wr(2'd3, 16'h001f);
    @(negedge clk); chk(rdata == 0, "R6 0x1f clears all", rdata, 0);
    tick();

    repeat (4) tick();
    finish_run();
  end
endmodule